// File: doc/BRIEF.md
# Bit-Serial AES-128 Round-Key Generator

This block supplies AES-128 round keys one bit per clock to a bit-serial cipher datapath. The 128-bit key is loaded serially. On every advance cycle the block emits one bit of the current round key and writes one bit of the next round key into the same rotating register. After 128 advance cycles the register holds the next round key, ready for the following pass. When the advance input is low the register is frozen, so the datapath can spend cycles on its row shifting and column mixing without losing key bits.

Bits leave and enter in row-major byte order: bytes 0, 4, 8, 12, then 1, 5, 9, 13, then 2, 6, 10, 14, then 3, 7, 11, 15, each byte MSB first. Here byte b is byte b of the standard key, with byte 0 being the most significant byte. The substitution box is outside the block. Once per row the block presents one byte and takes the substituted byte back combinationally in the same cycle. It holds the result in a small shift buffer and uses it bit by bit. Each new byte is formed serially as an exclusive-OR with the new byte of the previous column, which is tapped from eight register places behind the write point. The round constant is produced serially from its own register.

Top module: `serial_keyexp`

## Requirements
- R1: After reset, with no advance, rk_bit_o is 0, sb_req_o is 0 and sb_byte_o is 0x00.
- R2: While load_i is high, each cycle shifts key_bit_i into the key register. Loading takes 128 cycles, in row-major byte order (0,4,8,12,1,5,...,15), MSB first. The first following pass emits the loaded key in that same order.
- R3: Each cycle with adv_i high and load_i low consumes one bit. rk_bit_o shows the current bit before the consuming edge. Pass k (k = 0..10, 128 advance cycles each) emits round key k of the AES-128 expansion in row-major byte order, MSB first.
- R4: A cycle with adv_i and load_i both low changes nothing. rk_bit_o holds its value, sb_req_o is 0, and later output continues where it stopped.
- R5: sb_req_o is high on advance cycles at pass positions 0, 32, 64 and 96, and on no other cycle. sb_byte_o then equals the current key's byte 13, 14, 15 and byte 12 respectively.
- R6: The round constant starts at 0x01 after a load. It is doubled in GF(2^8) modulo 0x11B at the end of every pass, so round keys 9 and 10 use 0x1B and 0x36.
- R7: When load_i and adv_i are high together, the load takes effect and no S-box request is raised.
- R8: A load started partway through a pass restarts the position at 0 and the round constant at 0x01. The reloaded key is then expanded correctly.
- R9: sb_byte_i is used only in a cycle where sb_req_o is high. Its value in all other cycles has no effect on the emitted keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Shift key_bit_i into the key register |
| key_bit_i | input | 1 | Serial key bit during loading |
| adv_i | input | 1 | Consume one round-key bit and compute one new bit |
| rk_bit_o | output | 1 | Current round-key bit |
| sb_req_o | output | 1 | S-box lookup valid this cycle |
| sb_byte_o | output | 8 | Byte to substitute |
| sb_byte_i | input | 8 | Substituted byte, combinational response |

## Verification
Two pairs of events can fall in the same cycle. The first is a freeze that lands exactly on a row-start position, which is the cycle where an S-box lookup would otherwise be captured. The bench holds adv_i low on those cycles in alternate passes and checks that no request appears. It also checks that the next advance still captures the correct byte. The second is a load that overlaps an advance in the middle of a pass. The bench raises both together and then compares all eleven round keys of the new key, bit by bit, against its own byte-wise expansion. While no lookup is valid, the bench drives random values on sb_byte_i.

// File: rtl/skx_pkg.sv
package skx_pkg;
  localparam int unsigned KEY_BITS = 128;
  localparam int unsigned SB_W     = 8;
  localparam logic [7:0]  RC_FIRST = 8'h01;
  localparam logic [8:0]  RC_POLY  = 9'h11B;

  // Multiply by x in GF(2^8) with the AES field polynomial.
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? RC_POLY[7:0] : 8'h00);
  endfunction
endpackage

// File: rtl/skx_ctrl.sv
module skx_ctrl #(
  parameter int unsigned POS_W = 7,
  parameter int unsigned BIT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  output logic             step_o,
  output logic             row_start_o,
  output logic             first_col_o,
  output logic             first_grp_o,
  output logic             last_row_o,
  output logic             pass_end_o,
  output logic [BIT_W-1:0] bitix_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int unsigned COL_LO = BIT_W;
  localparam int unsigned ROW_LO = BIT_W + 2;

  logic [POS_W-1:0] pos_q;
  logic [1:0] row, col;

  assign row     = pos_q[ROW_LO +: 2];
  assign col     = pos_q[COL_LO +: 2];
  assign bitix_o = pos_q[BIT_W-1:0];

  assign step_o      = adv_i & ~load_i;
  assign first_col_o = (col == 2'd0);
  assign row_start_o = first_col_o && (bitix_o == '0);
  assign first_grp_o = first_col_o && (row == 2'd0);
  assign last_row_o  = (row == 2'd3);
  assign pass_end_o  = step_o && (pos_q == {POS_W{1'b1}});
  assign pos_o       = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (load_i) pos_q <= '0;
    else if (step_o) pos_q <= pos_q + POS_W'(1);
  end
endmodule

// File: rtl/skx_rcon.sv
module skx_rcon import skx_pkg::*; #(
  parameter int unsigned BIT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             pass_end_i,
  input  logic             first_grp_i,
  input  logic [BIT_W-1:0] bitix_i,
  output logic             rc_bit_o,
  output logic [7:0]       rc_o
);
  logic [7:0] rc_q;

  // MSB first: bit index 0 of the group selects rc_q[7].
  assign rc_bit_o = first_grp_i & rc_q[~bitix_i];
  assign rc_o     = rc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rc_q <= RC_FIRST;
    else if (load_i)     rc_q <= RC_FIRST;
    else if (pass_end_i) rc_q <= gf_dbl(rc_q);
  end
endmodule

// File: rtl/skx_sbuf.sv
module skx_sbuf #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_new_i,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic [W-1:0] din_i,
  output logic         sub_bit_o
);
  logic [W-1:0] q;

  // The first bit comes straight from the response; the remaining ones are buffered.
  assign sub_bit_o = sel_new_i ? din_i[W-1] : q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (capture_i) q <= {din_i[W-2:0], 1'b0};
    else if (shift_i)   q <= {q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/serial_keyexp.sv
module serial_keyexp import skx_pkg::*; #(
  parameter int unsigned KEY_W  = KEY_BITS,
  parameter int unsigned BYTE_W = SB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              key_bit_i,
  input  logic              adv_i,
  output logic              rk_bit_o,
  output logic              sb_req_o,
  output logic [BYTE_W-1:0] sb_byte_o,
  input  logic [BYTE_W-1:0] sb_byte_i
);
  localparam int unsigned POS_W   = $clog2(KEY_W);
  localparam int unsigned BIT_W   = $clog2(BYTE_W);
  // Seven groups ahead of the read end sits the byte for the coming substitution.
  localparam int unsigned SEL_LO  = KEY_W - 8 * BYTE_W;
  localparam int unsigned PREV_LO = SEL_LO + BYTE_W;
  // The new bit of the previous column, same bit position, written one group ago.
  localparam int unsigned RUN_TAP = BYTE_W - 1;

  logic [KEY_W-1:0] kreg;
  logic step, row_start, first_col, first_grp, last_row, pass_end;
  logic [BIT_W-1:0] bitix;
  logic [POS_W-1:0] pos_q;
  logic [7:0] rc_q;
  logic rc_bit, sub_bit, new_bit, old_bit;

  skx_ctrl #(.POS_W(POS_W), .BIT_W(BIT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
    .step_o(step), .row_start_o(row_start), .first_col_o(first_col),
    .first_grp_o(first_grp), .last_row_o(last_row), .pass_end_o(pass_end),
    .bitix_o(bitix), .pos_o(pos_q)
  );

  skx_rcon #(.BIT_W(BIT_W)) rcon_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .pass_end_i(pass_end),
    .first_grp_i(first_grp), .bitix_i(bitix), .rc_bit_o(rc_bit), .rc_o(rc_q)
  );

  skx_sbuf #(.W(BYTE_W)) sbuf_i (
    .clk(clk), .rst_n(rst_n), .sel_new_i(row_start),
    .capture_i(step & row_start), .shift_i(step),
    .din_i(sb_byte_i), .sub_bit_o(sub_bit)
  );

  assign old_bit  = kreg[KEY_W-1];
  assign rk_bit_o = old_bit;
  assign sb_req_o = step & row_start;

  // In the last row the wanted old byte was already replaced; recover it from two new bytes.
  assign sb_byte_o = last_row ? (kreg[SEL_LO +: BYTE_W] ^ kreg[PREV_LO +: BYTE_W])
                              : kreg[SEL_LO +: BYTE_W];

  assign new_bit = first_col ? (old_bit ^ sub_bit ^ rc_bit)
                             : (old_bit ^ kreg[RUN_TAP]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      kreg <= '0;
    else if (load_i) kreg <= {kreg[KEY_W-2:0], key_bit_i};
    else if (step)   kreg <= {kreg[KEY_W-2:0], new_bit};
  end
endmodule

// File: rtl/skx_chk.sv
module skx_chk #(
  parameter int unsigned POS_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             adv_i,
  input logic             rk_bit_o,
  input logic             sb_req_o,
  input logic [POS_W-1:0] pos_q,
  input logic [7:0]       rc_q
);
  // R2
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pos_q == '0) && (rc_q == 8'h01));

  // R3
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> pos_q == POS_W'($past(pos_q) + 1'b1));

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(rk_bit_o) && $stable(pos_q) && $stable(rc_q));

  // R5
  req_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_o |=> !sb_req_o);

  // R6
  rc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(adv_i && pos_q == {POS_W{1'b1}})) |=> $stable(rc_q));

  // R6
  rc_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rc_q != 8'h00);
endmodule

bind serial_keyexp skx_chk #(.POS_W(POS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
  .rk_bit_o(rk_bit_o), .sb_req_o(sb_req_o), .pos_q(pos_q), .rc_q(rc_q)
);

// File: tb/serial_keyexp_tb_top.sv
module serial_keyexp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0, key_bit_i = 1'b0, adv_i = 1'b0;
  logic [7:0] sb_byte_i, noise = 8'h00;
  logic rk_bit_o, sb_req_o;
  logic [7:0] sb_byte_o;

  int checks = 0, errors = 0;
  logic [7:0] sbox_t [0:255];
  logic [7:0] rk_tab [0:10][0:15];
  int m_round = 0, m_pos = 0;
  bit m_live = 0;

  always #2 clk = ~clk;

  serial_keyexp dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_bit_i(key_bit_i),
    .adv_i(adv_i), .rk_bit_o(rk_bit_o), .sb_req_o(sb_req_o),
    .sb_byte_o(sb_byte_o), .sb_byte_i(sb_byte_i)
  );

  // R9: outside a lookup cycle the response lines carry random values
  always_comb sb_byte_i = sb_req_o ? sbox_t[sb_byte_o] : noise;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  task automatic build_sbox();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv = 8'h00, s;
      for (int y = 1; y < 256; y++)
        if (gmul(8'(v), 8'(y)) == 8'h01) inv = 8'(y);
      s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
              ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      sbox_t[v] = s;
    end
  endtask

  task automatic expand(input logic [127:0] key);
    logic [7:0] rc = 8'h01;
    logic [7:0] t [0:3];
    for (int b = 0; b < 16; b++) rk_tab[0][b] = key[127 - 8*b -: 8];
    for (int k = 1; k <= 10; k++) begin
      for (int r = 0; r < 4; r++) t[r] = sbox_t[rk_tab[k-1][12 + (r + 1) % 4]];
      t[0] ^= rc;
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          rk_tab[k][4*c + r] = rk_tab[k-1][4*c + r] ^ ((c == 0) ? t[r] : rk_tab[k][4*(c-1) + r]);
      rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
    end
  endtask

  function automatic logic [127:0] pack_rk(input int k);
    logic [127:0] v = '0;
    for (int b = 0; b < 16; b++) v[127 - 8*b -: 8] = rk_tab[k][b];
    return v;
  endfunction

  function automatic logic exp_bit(input int k, input int p);
    return rk_tab[k][4*((p/8) % 4) + p/32][7 - p % 8];
  endfunction

  task automatic step(input logic a, input logic l, input logic kb);
    @(negedge clk);
    adv_i = a; load_i = l; key_bit_i = kb; noise = 8'($urandom);
    #1;
    if (l) begin
      chk("R7 no lookup while loading", sb_req_o, 1'b0);
    end else if (m_live && m_round <= 10) begin
      chk((m_round == 0) ? "R2 loaded key bit" : "R3 R6 round key bit",
          rk_bit_o, exp_bit(m_round, m_pos));
      if (a) begin
        chk("R5 lookup position", sb_req_o, (m_pos % 32) == 0);
        if (m_pos % 32 == 0)
          chk("R5 R9 lookup byte", sb_byte_o,
              (m_pos / 32 < 3) ? rk_tab[m_round][13 + m_pos/32] : rk_tab[m_round][12]);
        m_pos++;
        if (m_pos == 128) begin m_pos = 0; m_round++; end
      end else begin
        chk("R4 no lookup when frozen", sb_req_o, 1'b0);
      end
    end
  endtask

  task automatic load_key(input logic [127:0] key, input logic with_adv);
    m_live = 0;
    for (int idx = 0; idx < 128; idx++) begin
      int b = 4*((idx/8) % 4) + idx/32;
      step(with_adv, 1'b1, key[127 - 8*b - idx % 8]);
    end
    expand(key);
    m_round = 0; m_pos = 0; m_live = 1;
  endtask

  task automatic run_key(input bit stalls);
    for (int k = 0; k <= 10; k++) begin
      for (int p = 0; p < 128; p++) begin
        if (stalls && (k % 2 == 1) && (p % 32 == 0)) begin
          step(1'b0, 1'b0, 1'b0);   // R4 freeze exactly on a lookup cycle
          step(1'b0, 1'b0, 1'b0);
        end
        if (stalls && ($urandom % 7 == 0)) step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
      end
      repeat (40) step(1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset key bit", rk_bit_o, 1'b0);
    chk("R1 reset lookup", sb_req_o, 1'b0);
    chk("R1 reset lookup byte", sb_byte_o, 8'h00);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    chk("R1 idle after reset", sb_req_o, 1'b0);

    // Reference sanity against published round keys
    expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    chk("R3 ref round1 hi", pack_rk(1)[127:96], 32'ha0fafe17);
    chk("R6 ref round10 hi", pack_rk(10)[127:96], 32'hd014f9a8);
    chk("R6 ref round10 lo", pack_rk(10)[31:0], 32'hb6630ca6);

    load_key(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0);
    run_key(1'b0);

    // R7: load together with advance; R8: reload partway through a pass
    load_key(128'h000102030405060708090a0b0c0d0e0f, 1'b1);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 1'b0);
    load_key({128{1'b1}}, 1'b1);
    run_key(1'b1);

    load_key(128'h000102030405060708090a0b0c0d0e0f, 1'b0);
    run_key(1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule